// File: doc/BRIEF.md
# Silence-Gated Elastic Audio Buffer

This block carries a stream of stereo audio frames from a source clock domain into a domain paced by an independent, stable local clock. Frames enter with the source's timing on a write-side valid strobe and leave one per output strobe on the read side, so the outgoing stream keeps none of the incoming jitter. The buffer is deep and is run about half full, which adds a large, roughly constant delay between input and output.

The two clocks never agree exactly, so the fill level drifts. The block corrects that drift only where nobody can hear it: inside long runs of exact digital silence, where every bit of both channels is zero. Within such a run it discards zero frames when the buffer is too full and emits extra zero frames when the buffer is too empty. Frames with audio content always pass one per strobe, unchanged and in order. The depth is a parameter and can be set large enough for half a second of audio at 44.1 kHz (about 22050 frames, rounded up to a power of two). The default is a smaller value.

Top module: `silence_slip_fifo`

## Requirements
- R1: After reset both fill levels read 0, the priming flag, the overflow flag and both slip flags are 0, and the output frame is all zero.
- R2: A frame is one 24-bit left and one 24-bit right sample, stored as one entry. Frames leave in the order they were written, left and right kept together.
- R3: Until the read-side fill first reaches DEPTH/2 after reset, each output strobe yields an all-zero frame and consumes nothing. The priming flag then goes to 1 and stays there.
- R4: Once primed, an output strobe that finds the buffer empty yields an all-zero frame and consumes nothing.
- R5: A write that arrives when the write-side fill equals DEPTH is discarded. The overflow flag then goes to 1 and stays set until reset.
- R6: A silent run becomes long once SIL_LEN consecutive all-zero frames have been consumed. One consumed frame with any non-zero bit clears the count.
- R7: In a long silent run, when the read fill exceeds DEPTH/2+MARGIN and both the head frame and the one after it are zero, a strobe consumes two frames, outputs one zero frame and pulses the drop flag.
- R8: In a long silent run, when the read fill is nonzero and below DEPTH/2-MARGIN and the head frame is zero, a strobe outputs a zero frame without consuming anything and pulses the insert flag.
- R9: A frame with any non-zero bit is never dropped or repeated. Whatever the fill, each strobe over such data consumes exactly one frame. A strobe never performs more than one slip.
- R10: Each domain reports its own fill level from Gray-coded pointers synchronized through two flops. Once the other side is idle, both fills settle at the true count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Source-side clock |
| wrst_n | input | 1 | Source-side asynchronous reset, active low |
| wvalid | input | 1 | Incoming frame is valid this cycle |
| wleft | input | DW | Incoming left sample |
| wright | input | DW | Incoming right sample |
| wfill | output | AW+1 | Fill level seen from the source side |
| woverflow | output | 1 | Sticky: a frame was discarded because the buffer was full |
| rclk | input | 1 | Local output clock |
| rrst_n | input | 1 | Output-side asynchronous reset, active low |
| rstrobe | input | 1 | Request for one output frame |
| rleft | output | DW | Outgoing left sample |
| rright | output | DW | Outgoing right sample |
| rfill | output | AW+1 | Fill level seen from the output side |
| rprimed | output | 1 | Buffer has reached its target fill since reset |
| rslip_drop | output | 1 | One-cycle pulse: this strobe removed a zero frame |
| rslip_add | output | 1 | One-cycle pulse: this strobe inserted a zero frame |

## Verification
The embedded assertions check on every cycle that fills stay within the depth, that overflow never clears, that a full buffer does not advance its write pointer, that output stays silent before priming, and that a slip always emits a zero frame and never drops and inserts at once. Only the bench's scenarios can show the cases that depend on history: whether a drop or insert happens on exactly the right strobe, whether the silence count resets on audio, whether music passes untouched at a high fill, and whether the discarded overflow frame really disappears from the output sequence.

// File: rtl/silence_slip_fifo.sv
module silence_slip_fifo #(
  parameter int DW      = 24,
  parameter int DEPTH   = 1024,
  parameter int SIL_LEN = 4096,
  parameter int MARGIN  = 64
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wvalid,
  input  logic [DW-1:0] wleft,
  input  logic [DW-1:0] wright,
  output logic [$clog2(DEPTH):0] wfill,
  output logic          woverflow,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rstrobe,
  output logic [DW-1:0] rleft,
  output logic [DW-1:0] rright,
  output logic [$clog2(DEPTH):0] rfill,
  output logic          rprimed,
  output logic          rslip_drop,
  output logic          rslip_add
);
  localparam int AW     = $clog2(DEPTH);
  localparam int PW     = AW + 1;
  localparam int FW     = 2 * DW;
  localparam int TARGET = DEPTH / 2;
  localparam int HI     = TARGET + MARGIN;
  localparam int LO     = TARGET - MARGIN;
  localparam int CW     = $clog2(SIL_LEN + 1);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [FW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, wgray, rptr, rgray;
  logic [PW-1:0] rg_s1, rg_s2, wg_s1, wg_s2;

  // write domain
  assign wgray = wptr ^ (wptr >> 1);
  assign wfill = wptr - g2b(rg_s2);
  wire wfull = (wfill == PW'(DEPTH));

  always_ff @(posedge wclk or negedge wrst_n)
    if (!wrst_n) begin
      wptr <= '0;
      woverflow <= 1'b0;
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wvalid && wfull) woverflow <= 1'b1;
      else if (wvalid) wptr <= wptr + 1'b1;
    end

  always_ff @(posedge wclk)
    if (wvalid && !wfull) mem[wptr[AW-1:0]] <= {wleft, wright};

  // read domain
  assign rgray = rptr ^ (rptr >> 1);
  assign rfill = g2b(wg_s2) - rptr;

  logic [CW-1:0] sil_cnt;
  wire [FW-1:0] head = mem[rptr[AW-1:0]];
  wire [FW-1:0] nxt  = mem[rptr[AW-1:0] + AW'(1)];
  wire long_run = (sil_cnt == CW'(SIL_LEN));
  wire empty    = (rfill == '0);
  wire do_drop  = long_run && head == '0 && nxt == '0 && int'(rfill) > HI;
  wire do_add   = long_run && head == '0 && int'(rfill) < LO;

  always_ff @(posedge rclk or negedge rrst_n)
    if (!rrst_n) begin
      rptr <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
      rprimed <= 1'b0;
      sil_cnt <= '0;
      {rleft, rright} <= '0;
      rslip_drop <= 1'b0;
      rslip_add <= 1'b0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      rslip_drop <= 1'b0;
      rslip_add <= 1'b0;
      if (!rprimed) begin
        if (int'(rfill) >= TARGET) rprimed <= 1'b1;
      end else if (rstrobe) begin
        if (empty) begin
          {rleft, rright} <= '0;
        end else if (do_drop) begin
          {rleft, rright} <= '0;
          rptr <= rptr + PW'(2);
          rslip_drop <= 1'b1;
        end else if (do_add) begin
          {rleft, rright} <= '0;
          rslip_add <= 1'b1;
        end else begin
          {rleft, rright} <= head;
          rptr <= rptr + 1'b1;
          if (head != '0) sil_cnt <= '0;
          else if (!long_run) sil_cnt <= sil_cnt + 1'b1;
        end
      end
    end

  assert_wfill_bound_R10: assert property (@(posedge wclk) disable iff (!wrst_n)
    int'(wfill) <= DEPTH);
  assert_rfill_bound_R10: assert property (@(posedge rclk) disable iff (!rrst_n)
    int'(rfill) <= DEPTH);
  assert_no_write_when_full_R5: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wvalid && wfill == PW'(DEPTH)) |=> $stable(wptr));
  assert_overflow_sticky_R5: assert property (@(posedge wclk) disable iff (!wrst_n)
    woverflow |=> woverflow);
  assert_unprimed_silent_R3: assert property (@(posedge rclk) disable iff (!rrst_n)
    !rprimed |-> (rleft == '0 && rright == '0));
  assert_primed_sticky_R3: assert property (@(posedge rclk) disable iff (!rrst_n)
    rprimed |=> rprimed);
  assert_slip_is_silent_R7: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rslip_drop || rslip_add) |-> (rleft == '0 && rright == '0));
  assert_single_slip_R9: assert property (@(posedge rclk) disable iff (!rrst_n)
    !(rslip_drop && rslip_add));
endmodule

// File: tb/sim_silence_slip_fifo.sv
module sim_silence_slip_fifo;
  localparam int DW = 24, DEPTH = 16, SIL = 4, MG = 2;
  logic wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
  logic wvalid = 0, rstrobe = 0;
  logic [DW-1:0] wleft = '0, wright = '0;
  logic [DW-1:0] rleft, rright;
  logic [4:0] wfill, rfill;
  logic woverflow, rprimed, rslip_drop, rslip_add;
  int errors = 0, checks = 0;
  logic sd, sa;

  always #10 wclk = ~wclk;
  always #7  rclk = ~rclk;

  silence_slip_fifo #(.DW(DW), .DEPTH(DEPTH), .SIL_LEN(SIL), .MARGIN(MG)) u0 (
    .wclk(wclk), .wrst_n(wrst_n), .wvalid(wvalid), .wleft(wleft), .wright(wright),
    .wfill(wfill), .woverflow(woverflow), .rclk(rclk), .rrst_n(rrst_n),
    .rstrobe(rstrobe), .rleft(rleft), .rright(rright), .rfill(rfill),
    .rprimed(rprimed), .rslip_drop(rslip_drop), .rslip_add(rslip_add));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    wvalid = 0; rstrobe = 0;
    wrst_n = 0; rrst_n = 0;
    repeat (3) @(negedge wclk);
    wrst_n = 1; rrst_n = 1;
    repeat (2) @(negedge wclk);
  endtask

  task automatic wr(int l, int r);
    @(negedge wclk);
    wvalid = 1; wleft = DW'(l); wright = DW'(r);
    @(negedge wclk);
    wvalid = 0;
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (6) @(negedge wclk);
  endtask

  task automatic rd();
    @(negedge rclk);
    rstrobe = 1;
    @(negedge rclk);
    rstrobe = 0;
    sd = rslip_drop; sa = rslip_add;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 wfill", int'(wfill), 0);
    chk("R1 rfill", int'(rfill), 0);
    chk("R1 primed", int'(rprimed), 0);
    chk("R1 overflow", int'(woverflow), 0);
    chk("R1 slips", int'(rslip_drop) + int'(rslip_add), 0);
    chk("R1 output", int'(rleft) + int'(rright), 0);
  endtask

  task automatic t_prime_order();
    do_reset();
    for (int i = 1; i <= 4; i++) wr(i, i + 100);
    settle();
    rd();
    chk("R3 unprimed output", int'(rleft), 0);
    chk("R3 unprimed no consume", int'(rfill), 4);
    chk("R3 not primed", int'(rprimed), 0);
    for (int i = 5; i <= 8; i++) wr(i, i + 100);
    settle();
    chk("R10 wfill settled", int'(wfill), 8);
    chk("R3 primed at target", int'(rprimed), 1);
    for (int i = 1; i <= 8; i++) begin
      rd();
      chk("R2 left order", int'(rleft), i);
      chk("R2 right order", int'(rright), i + 100);
    end
    chk("R10 rfill drained", int'(rfill), 0);
    rd();
    chk("R4 empty output", int'(rleft) + int'(rright), 0);
    chk("R4 empty fill", int'(rfill), 0);
    settle();
    chk("R10 wfill drained", int'(wfill), 0);
  endtask

  task automatic t_drop();
    do_reset();
    for (int i = 0; i < 16; i++) wr(0, 0);
    settle();
    for (int i = 0; i < 4; i++) begin
      rd();
      chk("R6 no slip before long run", int'(sd) + int'(sa), 0);
    end
    chk("R6 fill after four reads", int'(rfill), 12);
    rd();
    chk("R7 drop flag", int'(sd), 1);
    chk("R7 two consumed", int'(rfill), 10);
    rd();
    chk("R7 stop at margin", int'(sd), 0);
    chk("R7 fill after normal read", int'(rfill), 9);
  endtask

  task automatic t_music_full();
    do_reset();
    for (int i = 1; i <= 16; i++) wr(i, 0);
    settle();
    for (int i = 1; i <= 6; i++) begin
      rd();
      chk("R9 music value", int'(rleft), i);
      chk("R9 one per strobe", int'(rfill), 16 - i);
    end
  endtask

  task automatic t_add();
    do_reset();
    for (int i = 0; i < 8; i++) wr(0, 0);
    settle();
    for (int i = 0; i < 4; i++) rd();
    chk("R8 fill before insert", int'(rfill), 4);
    rd();
    chk("R8 insert flag", int'(sa), 1);
    chk("R8 nothing consumed", int'(rfill), 4);
    chk("R8 zero emitted", int'(rleft) + int'(rright), 0);
  endtask

  task automatic t_add_blocked_by_music();
    do_reset();
    for (int i = 0; i < 4; i++) wr(0, 0);
    for (int i = 0; i < 4; i++) wr(7, 7);
    settle();
    for (int i = 0; i < 4; i++) rd();
    rd();
    chk("R9 no insert on music", int'(sa), 0);
    chk("R9 music value", int'(rright), 7);
    chk("R9 music consumed", int'(rfill), 3);
  endtask

  task automatic t_count_reset();
    do_reset();
    for (int i = 0; i < 3; i++) wr(0, 0);
    wr(0, 5);
    for (int i = 0; i < 4; i++) wr(0, 0);
    settle();
    for (int i = 0; i < 7; i++) rd();
    chk("R6 count reset fill", int'(rfill), 1);
    rd();
    chk("R6 no insert after reset count", int'(sa), 0);
    chk("R6 last frame consumed", int'(rfill), 0);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 1; i <= 17; i++) wr(i, i);
    settle();
    chk("R5 overflow flag", int'(woverflow), 1);
    chk("R5 wfill full", int'(wfill), 16);
    for (int i = 1; i <= 16; i++) begin
      rd();
      if (i == 16) chk("R5 last kept frame", int'(rleft), 16);
    end
    chk("R5 extra frame discarded", int'(rfill), 0);
    settle();
    chk("R5 overflow sticky", int'(woverflow), 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_prime_order();
        t_drop();
        t_music_full();
        t_add();
        t_add_blocked_by_music();
        t_count_reset();
        t_overflow();
      end
      begin
        repeat (100000) @(posedge wclk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule